// File: doc/BRIEF.md
# Tamper Event and Secret-Erase Controller

This block gathers already-filtered tamper detection pulses from three external channels and four internal sources. It turns them into sticky status flags, a masked interrupt status, one interrupt line, per-channel trigger pulses and a one-cycle event pulse that a timestamp unit can capture. It also holds a bank of 32 backup words of 32 bits each. The bank is wiped, and read as zero, for as long as any flag that may erase is set.

Software reaches the block over a simple word bus with a combinational read path. A write-protect enable input gates every write. Each external channel has a mask option and a no-erase option. Masking keeps the trigger pulse but drops the flag and the wipe, so a downstream timer can be triggered with no software clear. No-erase keeps the flag but protects the bank. The block has two resets. The domain reset clears everything. The system reset clears only the output pulse registers and leaves the configuration, flags and backup words intact.

Top module: `tamper_guard`

## Requirements
- R1: When a source is enabled, a detection pulse on it sets that source's status flag on the next clock edge, and the flag stays set. A detection on a disabled source sets nothing. In the status word (0x0C), external channel k is bit k (k = 0..2) and internal source 3+j is bit 18+j (j = 0..3).
- R2: While a source's flag is set, further detections on that source are ignored: they produce no trigger pulse and no event pulse.
- R3: Writing 1 to a source's bit in the clear register (0x14) clears its flag. Writing 0 has no effect. If a new detection and a clear reach the same flag in the same cycle, the flag ends up set.
- R4: When an external channel's mask bit (option register 0x04, bit k) is set, a detection still pulses trig_out[k], but its flag stays clear and the backup words are not erased.
- R5: When an external channel's no-erase bit (option register 0x04, bit 8+k) is set, its flag is set as usual but the backup words keep their contents.
- R6: While at least one flag that may erase is set, erase_req is high, every backup word reads as zero and is held at zero, and backup writes are lost. Internal source flags always may erase.
- R7: The masked status (0x10) equals the flags ANDed with the interrupt enables (0x08, same bit layout as status). irq is the OR of the masked status bits.
- R8: Every write (configuration, clear and backup) is ignored unless wp_en is high.
- R9: Backup word x sits at byte offset 0x100 + 4*x, for x = 0..31. After a domain reset, the enable register (0x00, same bit layout as status) reads 0x003C0000, and the flags, interrupt enables and backup words read as zero.
- R10: Each accepted detection, internal or external, gives a one-cycle evt_out pulse one cycle after the detection. Each accepted external detection also gives a one-cycle pulse on its trig_out bit.
- R11: Asserting sys_rst leaves the configuration, the flags and the backup words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| dom_rst | input | 1 | Domain reset, synchronous, active high; clears all state |
| sys_rst | input | 1 | System reset, synchronous, active high; clears only pulse outputs |
| ext_det | input | 3 | Filtered detection pulses from the external channels |
| int_det | input | 4 | Detection pulses from internal sources 3..6 |
| wp_en | input | 1 | Write-permit; writes take effect only when high |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt line |
| trig_out | output | 3 | One-cycle trigger per external channel |
| evt_out | output | 1 | One-cycle pulse on any accepted detection |
| erase_req | output | 1 | High while the backup bank is being held at zero |

## Verification
All the results that the registers hold appear one clock edge after their cause: a flag after its detection or clear, a configuration or backup word after its write, and the trigger and event pulses in the cycle after the detection. The combinational results come in the same cycle as the flags they follow: erase_req, irq, masked status and the zeroed read data. The bench drives inputs on the falling edge and samples on the following falling edge. That puts exactly one rising edge between a stimulus and its check. It then samples once more to confirm that the pulses last a single cycle. Reads set the address and sample after a short settle delay. No clock edge falls inside that window.

// File: rtl/tg_pkg.sv
package tg_pkg;
    localparam int EXT_N   = 3;
    localparam int INT_N   = 4;
    localparam int SRC_N   = EXT_N + INT_N;
    localparam int INT_LSB = 18;
    localparam int NOER_LSB = 8;
    localparam int DW      = 32;

    localparam int A_EN   = 'h00;
    localparam int A_OPT  = 'h04;
    localparam int A_IE   = 'h08;
    localparam int A_SR   = 'h0C;
    localparam int A_MISR = 'h10;
    localparam int A_CLR  = 'h14;
    localparam int A_BKP  = 'h100;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic [EXT_N-1:0] mask;
        logic [EXT_N-1:0] noer;
        logic [SRC_N-1:0] ie;
    } cfg_t;

    localparam logic [SRC_N-1:0] EN_RESET = {{INT_N{1'b1}}, {EXT_N{1'b0}}};

    function automatic logic [DW-1:0] src_to_word(input logic [SRC_N-1:0] v);
        logic [DW-1:0] w;
        w = '0;
        w[EXT_N-1:0] = v[EXT_N-1:0];
        w[INT_LSB +: INT_N] = v[SRC_N-1:EXT_N];
        return w;
    endfunction

    function automatic logic [SRC_N-1:0] word_to_src(input logic [DW-1:0] w);
        return {w[INT_LSB +: INT_N], w[EXT_N-1:0]};
    endfunction
endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import tg_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              dom_rst,
    input  logic              wr,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output cfg_t              cfg,
    output logic [SRC_N-1:0]  clr
);
    logic wr_ok;
    assign wr_ok = wr && wp_en;

    always_ff @(posedge clk) begin
        if (dom_rst) begin
            cfg.en   <= EN_RESET;
            cfg.mask <= '0;
            cfg.noer <= '0;
            cfg.ie   <= '0;
        end else if (wr_ok) begin
            if (32'(addr) == A_EN)  cfg.en <= word_to_src(wdata);
            if (32'(addr) == A_IE)  cfg.ie <= word_to_src(wdata);
            if (32'(addr) == A_OPT) begin
                cfg.mask <= wdata[EXT_N-1:0];
                cfg.noer <= wdata[NOER_LSB +: EXT_N];
            end
        end
    end

    always_comb begin
        clr = '0;
        if (wr_ok && 32'(addr) == A_CLR) clr = word_to_src(wdata);
    end

    // R8: without a permitted write the configuration holds
    a_r8_cfg_locked: assert property (@(posedge clk) disable iff (dom_rst)
        !wr_ok |=> $stable(cfg));
endmodule

// File: rtl/tg_flags.sv
module tg_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         dom_rst,
    input  logic         sys_rst,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] acc_q
);
    logic [N-1:0] take;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign take[i] = hit[i] && !flag_q[i];

        always_ff @(posedge clk) begin
            if (dom_rst)       flag_q[i] <= 1'b0;
            else if (mask[i])  flag_q[i] <= 1'b0;
            else if (take[i])  flag_q[i] <= 1'b1;
            else if (clr[i])   flag_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (dom_rst || sys_rst) acc_q[i] <= 1'b0;
            else                    acc_q[i] <= take[i];
        end

        // R1: an accepted unmasked detection latches the flag
        a_r1_flag_sets: assert property (@(posedge clk) disable iff (dom_rst)
            (hit[i] && !flag_q[i] && !mask[i]) |=> flag_q[i]);
        // R2: a set flag blocks the next pulse
        a_r2_no_retrigger: assert property (@(posedge clk) disable iff (dom_rst)
            (flag_q[i] && hit[i]) |=> !acc_q[i]);
        // R3: set wins over a clear in the same cycle
        a_r3_set_wins: assert property (@(posedge clk) disable iff (dom_rst)
            (hit[i] && !flag_q[i] && !mask[i] && clr[i]) |=> flag_q[i]);
        // R4: a masked source never holds a flag
        a_r4_mask_clears: assert property (@(posedge clk) disable iff (dom_rst)
            mask[i] |=> !flag_q[i]);
    end
endmodule

// File: rtl/tg_backup.sv
module tg_backup #(
    parameter int WORDS = 32,
    parameter int W     = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             dom_rst,
    input  logic             erase,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] bank [WORDS];
    logic         bank_nz;

    always_ff @(posedge clk) begin
        if (dom_rst || erase) begin
            for (int k = 0; k < WORDS; k++) bank[k] <= '0;
        end else if (we) begin
            bank[idx] <= wdata;
        end
    end

    assign rdata = erase ? '0 : bank[idx];

    always_comb begin
        bank_nz = 1'b0;
        for (int k = 0; k < WORDS; k++) bank_nz = bank_nz | (|bank[k]);
    end

    // R6: one cycle of erase leaves the whole bank empty
    a_r6_bank_wiped: assert property (@(posedge clk) disable iff (dom_rst)
        erase |=> !bank_nz);
endmodule

// File: rtl/tamper_guard.sv
module tamper_guard
    import tg_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BKP_N  = 32,
    localparam int IDX_W = $clog2(BKP_N)
) (
    input  logic              clk,
    input  logic              dom_rst,
    input  logic              sys_rst,
    input  logic [EXT_N-1:0]  ext_det,
    input  logic [INT_N-1:0]  int_det,
    input  logic              wp_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic [EXT_N-1:0]  trig_out,
    output logic              evt_out,
    output logic              erase_req
);
    cfg_t             cfg;
    logic [SRC_N-1:0] clr, hit, mask_v, flag_q, acc_q, may_erase, pend;
    logic             bkp_sel, bkp_we;
    logic [DW-1:0]    bkp_rdata;

    tg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .dom_rst(dom_rst), .wr(bus_wr), .wp_en(wp_en),
        .addr(bus_addr), .wdata(bus_wdata), .cfg(cfg), .clr(clr)
    );

    assign hit       = {int_det, ext_det} & cfg.en;
    assign mask_v    = {{INT_N{1'b0}}, cfg.mask};
    assign may_erase = {{INT_N{1'b1}}, ~cfg.noer};

    tg_flags #(.N(SRC_N)) u_flags (
        .clk(clk), .dom_rst(dom_rst), .sys_rst(sys_rst),
        .hit(hit), .mask(mask_v), .clr(clr),
        .flag_q(flag_q), .acc_q(acc_q)
    );

    assign erase_req = |(flag_q & may_erase);
    assign pend      = flag_q & cfg.ie;
    assign irq       = |pend;
    assign trig_out  = acc_q[EXT_N-1:0];
    assign evt_out   = |acc_q;

    assign bkp_sel = (32'(bus_addr) >= A_BKP) && (32'(bus_addr) < A_BKP + 4 * BKP_N)
                     && (bus_addr[1:0] == 2'b00);
    assign bkp_we  = bus_wr && wp_en && bkp_sel;

    tg_backup #(.WORDS(BKP_N), .W(DW)) u_bkp (
        .clk(clk), .dom_rst(dom_rst), .erase(erase_req), .we(bkp_we),
        .idx(bus_addr[IDX_W+1:2]), .wdata(bus_wdata), .rdata(bkp_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (bkp_sel) bus_rdata = bkp_rdata;
        else if (32'(bus_addr) == A_EN)   bus_rdata = src_to_word(cfg.en);
        else if (32'(bus_addr) == A_IE)   bus_rdata = src_to_word(cfg.ie);
        else if (32'(bus_addr) == A_SR)   bus_rdata = src_to_word(flag_q);
        else if (32'(bus_addr) == A_MISR) bus_rdata = src_to_word(pend);
        else if (32'(bus_addr) == A_OPT) begin
            bus_rdata[EXT_N-1:0] = cfg.mask;
            bus_rdata[NOER_LSB +: EXT_N] = cfg.noer;
        end
    end

    // R10: the event pulse lasts one cycle unless a new detection is accepted
    a_r10_evt_single: assert property (@(posedge clk) disable iff (dom_rst || sys_rst)
        (evt_out && !(|(hit & ~flag_q))) |=> !evt_out);
    // R11: the system reset leaves the flags alone
    a_r11_sysrst_keeps: assert property (@(posedge clk) disable iff (dom_rst)
        (sys_rst && !(|hit) && !(|clr) && !(|mask_v)) |=> $stable(flag_q));
endmodule

// File: tb/tamper_guard_bench.sv
module tamper_guard_bench;
    logic        clk = 0;
    logic        dom_rst, sys_rst, wp_en, bus_wr, irq, evt_out, erase_req;
    logic [2:0]  ext_det, trig_out;
    logic [3:0]  int_det;
    logic [8:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    int          n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    tamper_guard u_tamper_guard (
        .clk(clk), .dom_rst(dom_rst), .sys_rst(sys_rst), .ext_det(ext_det),
        .int_det(int_det), .wp_en(wp_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .trig_out(trig_out),
        .evt_out(evt_out), .erase_req(erase_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ext(input int k);
        @(negedge clk); ext_det[k] = 1;
        @(negedge clk); ext_det[k] = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(9'h000, d); check("R9 enable reset", d, 32'h003C0000);
        rd(9'h00C, d); check("R9 status reset", d, 0);
        rd(9'h104, d); check("R9 backup reset", d, 0);
        check("R9 irq/erase reset", {irq, erase_req}, 0);
    endtask

    task automatic t_protect();
        logic [31:0] d;
        wp_en = 0;
        wr(9'h000, 32'h7); wr(9'h100, 32'hDEAD);
        rd(9'h000, d); check("R8 enable locked", d, 32'h003C0000);
        rd(9'h100, d); check("R8 backup locked", d, 0);
        wp_en = 1;
    endtask

    task automatic t_backup();
        logic [31:0] d;
        wr(9'h100, 32'h11112222); wr(9'h17C, 32'hCAFEF00D);
        rd(9'h100, d); check("R9 word0", d, 32'h11112222);
        rd(9'h17C, d); check("R9 word31", d, 32'hCAFEF00D);
    endtask

    task automatic t_detect();
        logic [31:0] d;
        pulse_ext(0);
        rd(9'h00C, d); check("R1 disabled ignored", d, 0);
        wr(9'h000, 32'h003C0007); wr(9'h008, 32'h1);
        pulse_ext(0);
        check("R10 trig0 pulse", {29'b0, trig_out}, 32'h1);
        check("R10 evt pulse", {31'b0, evt_out}, 1);
        rd(9'h00C, d); check("R1 flag0 set", d, 32'h1);
        check("R6 erase_req", {31'b0, erase_req}, 1);
        rd(9'h17C, d); check("R6 backup zero", d, 0);
        rd(9'h010, d); check("R7 misr", d, 32'h1);
        check("R7 irq", {31'b0, irq}, 1);
        @(negedge clk);
        check("R10 evt one cycle", {31'b0, evt_out}, 0);
        pulse_ext(0);
        check("R2 no retrigger", {28'b0, evt_out, trig_out}, 0);
        wr(9'h008, 32'h0);
        check("R7 irq off", {31'b0, irq}, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(9'h014, 32'h0);
        rd(9'h00C, d); check("R3 zero write no effect", d, 32'h1);
        wr(9'h014, 32'h1);
        rd(9'h00C, d); check("R3 clear flag0", d, 0);
        check("R6 erase released", {31'b0, erase_req}, 0);
        rd(9'h100, d); check("R6 bank stays wiped", d, 0);
        @(negedge clk);
        ext_det[1] = 1; bus_wr = 1; bus_addr = 9'h014; bus_wdata = 32'h2;
        @(negedge clk);
        ext_det[1] = 0; bus_wr = 0;
        rd(9'h00C, d); check("R3 set wins", d, 32'h2);
        wr(9'h014, 32'h2);
    endtask

    task automatic t_options();
        logic [31:0] d;
        wr(9'h108, 32'h5A5A);
        wr(9'h004, 32'h0000_0104);
        pulse_ext(2);
        check("R4 masked trig", {29'b0, trig_out}, 32'h4);
        rd(9'h00C, d); check("R4 masked no flag", d, 0);
        rd(9'h108, d); check("R4 no erase", d, 32'h5A5A);
        pulse_ext(0);
        rd(9'h00C, d); check("R5 noerase flag", d, 32'h1);
        check("R5 erase_req low", {31'b0, erase_req}, 0);
        rd(9'h108, d); check("R5 backup kept", d, 32'h5A5A);
        wr(9'h014, 32'h1);
        wr(9'h004, 32'h0);
    endtask

    task automatic t_sysrst();
        logic [31:0] d;
        wr(9'h00C + 9'h008, 32'h0);
        wr(9'h110, 32'h1234);
        wr(9'h004, 32'h0000_0100);
        pulse_ext(0);
        @(negedge clk); sys_rst = 1;
        @(negedge clk); sys_rst = 0;
        rd(9'h110, d); check("R11 backup kept", d, 32'h1234);
        rd(9'h00C, d); check("R11 flag kept", d, 32'h1);
        rd(9'h004, d); check("R11 config kept", d, 32'h100);
        wr(9'h014, 32'h1);
        wr(9'h004, 32'h0);
    endtask

    task automatic t_internal();
        logic [31:0] d;
        @(negedge clk); int_det[0] = 1;
        @(negedge clk); int_det[0] = 0;
        check("R10 internal evt", {28'b0, evt_out, trig_out}, 32'h8);
        rd(9'h00C, d); check("R1 internal flag bit18", d, 32'h0004_0000);
        check("R6 internal erase", {31'b0, erase_req}, 1);
        rd(9'h110, d); check("R6 internal wipes", d, 0);
        wr(9'h014, 32'h0004_0000);
        rd(9'h00C, d); check("R3 internal clear", d, 0);
    endtask

    initial begin
        dom_rst = 1; sys_rst = 1; wp_en = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        ext_det = 0; int_det = 0;
        repeat (3) @(negedge clk);
        dom_rst = 0; sys_rst = 0;
        t_reset();
        t_protect();
        t_backup();
        t_detect();
        t_clear();
        t_options();
        t_sysrst();
        t_internal();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule